// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Aggregator

This block gathers the interrupt sources of a PCIe root port into a few host interrupt lines. There are three kinds of source. Message-signalled interrupts arrive as inbound writes to a fixed target offset, and the written value is the vector number. The four legacy INTx wires are level inputs. Six error-event pulses come from the port's error detection logic. Each source is latched into a status bit that also has an enable bit. A host line is raised whenever its group holds a status bit that is both pending and enabled.

The 32 message vectors are striped across eight output lines. The low three bits of the vector pick the line, and the upper two bits pick the bit within that line's four-bit group. Software reads status through a simple register port and clears bits by writing ones. It changes enables only through separate set and clear registers. It writes a group code to a shared end-of-interrupt register, which forces a one-cycle low pulse on that line so that an edge-sensitive interrupt controller sees a fresh edge for anything still pending.

Top module: `pcie_irq_aggregator`

## Requirements
- R1: An inbound write with `msi_in_valid` high, `msi_in_addr` equal to 0x054 and `msi_in_data` below 32 sets bit `data/8` of message group `data%8` on the next clock edge. A write to any other address, or one whose value is 32 or more, changes no status.
- R2: The status of message group b (0..7) is read at bits [3:0] of 0x104+0x10*b. Writing a 1 to a bit at that address clears it, and writing a 0 leaves it unchanged.
- R3: For message group b, writing ones to 0x108+0x10*b sets those enable bits and writing ones to 0x10C+0x10*b clears them. A read of either address returns the enable bits. Enables change through nothing else.
- R4: `msi_irq[b]` is high in the cycle after an edge at which group b holds a bit that is both pending and enabled. A pending bit that is disabled does not raise the line.
- R5: A write to 0x050 with value c holds the INTx line c low for the next cycle when c is 0..3. With value 4+b it holds message line b low for the next cycle. The line re-asserts one cycle later if its group is still pending and enabled.
- R6: The status of INTx line i (0..3) is bit 0 of 0x184+0x10*i. The enable set is bit 0 of 0x188+0x10*i and the enable clear is bit 0 of 0x18C+0x10*i. While the line is enabled, its status follows `intx_level[i]` one edge later. While it is disabled, the status holds its value.
- R7: `intx_irq[i]` is high in the cycle after an edge at which INTx status i and enable i are both set.
- R8: The error status at 0x1C4 latches the `err_event` pulses. Bit 0 is system error, bit 1 fatal, bit 2 non-fatal, bit 3 correctable, bit 4 AXI tag lookup and bit 5 ECRC. Writing ones clears status bits. Writing ones to 0x1C8 sets enable bits, and a read there returns the enables. `err_irq` is high in the cycle after an edge at which any error bit is both pending and enabled.
- R9: When a new event on a status bit and a write-one-to-clear of the same bit occur in the same cycle, the bit remains set. This applies to message status and to error status.
- R10: After reset, every status bit, every enable bit and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, decoded from reg_addr |
| msi_in_valid | input | 1 | Inbound message write valid |
| msi_in_addr | input | 12 | Inbound message write offset |
| msi_in_data | input | 32 | Inbound message write data (vector) |
| intx_level | input | 4 | Legacy INTx level inputs A..D |
| err_event | input | 6 | Error event pulses |
| msi_irq | output | 8 | Host lines for message groups |
| intx_irq | output | 4 | Host lines for INTx |
| err_irq | output | 1 | Host line for errors |

## Verification
The bench sends vectors that sit at the edges of the striping: 0, 7, 8, 13, 26 and 31. A design that swaps the bank and bit fields would light the wrong line or the wrong status bit. It drives an event and a clear of the same bit in one cycle, where a design that gives the clear priority would lose the interrupt. It writes an end-of-interrupt while a source is still pending and expects exactly one low cycle, which catches both a missing gap and a line that stays low. It also sends a write to the wrong address, a vector out of range, a pending source that is disabled and then enabled, and an INTx input that rises while disabled. Each of these would reveal decode and masking faults that the plain path hides.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;

    localparam int ADDR_W     = 12;
    localparam int BANK_STEP  = 16;
    localparam int EOI_MSI_BASE = 4;

    localparam logic [ADDR_W-1:0] OFS_EOI       = 12'h050;
    localparam logic [ADDR_W-1:0] OFS_MSI_TGT   = 12'h054;
    localparam logic [ADDR_W-1:0] OFS_MSI_STAT  = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_MSI_ENSET = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_MSI_ENCLR = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_INT_STAT  = 12'h184;
    localparam logic [ADDR_W-1:0] OFS_INT_ENSET = 12'h188;
    localparam logic [ADDR_W-1:0] OFS_INT_ENCLR = 12'h18C;
    localparam logic [ADDR_W-1:0] OFS_ERR_STAT  = 12'h1C4;
    localparam logic [ADDR_W-1:0] OFS_ERR_ENSET = 12'h1C8;

    // Per-group register strobes decoded from the register port
    typedef struct packed {
        logic w1c;
        logic en_set;
        logic en_clr;
        logic eoi;
    } bank_ctl_t;

    function automatic logic [ADDR_W-1:0] bank_ofs(input logic [ADDR_W-1:0] base,
                                                   input int idx);
        return base + ADDR_W'(idx * BANK_STEP);
    endfunction

endpackage

// File: rtl/pcie_msi_stripe.sv
module pcie_msi_stripe
    import pcie_irq_pkg::*;
#(
    parameter int BANKS = 8,
    parameter int BITS  = 4,
    localparam int VEC_W  = $clog2(BANKS * BITS),
    localparam int BSEL_W = $clog2(BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       valid,
    input  logic [VEC_W-1:0]           vector,
    output logic [BANKS-1:0][BITS-1:0] events
);

    // Low vector bits pick the group, high bits pick the bit inside it
    always_comb begin
        events = '0;
        if (valid)
            events[vector[BSEL_W-1:0]][vector[VEC_W-1:BSEL_W]] = 1'b1;
    end

    // R1
    stripe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(events));

    // R1
    stripe_valid_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> ($countones(events) == 1));

endmodule

// File: rtl/pcie_irq_bank.sv
module pcie_irq_bank
    import pcie_irq_pkg::*;
#(
    parameter int W     = 4,
    parameter bit LEVEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  bank_ctl_t  ctl,
    input  logic [W-1:0] wbits,
    input  logic [W-1:0] src,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic       irq
);

    logic [W-1:0] stat_q, en_q, stat_n, en_n, clr_mask;

    assign clr_mask = ctl.w1c ? wbits : '0;

    always_comb begin
        en_n = en_q;
        if (ctl.en_set) en_n = en_n | wbits;
        if (ctl.en_clr) en_n = en_n & ~wbits;
    end

    generate
        if (LEVEL) begin : g_level
            // Enabled bits track their input; disabled bits hold
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign stat_n[i] = en_q[i] ? src[i] : (stat_q[i] & ~clr_mask[i]);
            end
        end else begin : g_edge
            // A new event overrides a clear of the same bit
            assign stat_n = (stat_q & ~clr_mask) | src;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
            irq    <= 1'b0;
        end else begin
            stat_q <= stat_n;
            en_q   <= en_n;
            irq    <= !ctl.eoi && (|(stat_q & en_q));
        end
    end

    assign status = stat_q;
    assign enable = en_q;

    // R5
    eoi_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.eoi |=> !irq);

    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(stat_q & en_q)));

    // R3
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctl.en_set || ctl.en_clr) |=> $stable(en_q));

    generate
        if (!LEVEL) begin : g_prio_chk
            // R9
            evt_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (|src) |=> ((stat_q & $past(src)) == $past(src)));
        end
    endgenerate

endmodule

// File: rtl/pcie_irq_aggregator.sv
module pcie_irq_aggregator
    import pcie_irq_pkg::*;
#(
    parameter int MSI_BANKS = 8,
    parameter int MSI_BITS  = 4,
    parameter int INTX_N    = 4,
    parameter int ERR_W     = 6,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              msi_in_valid,
    input  logic [11:0]       msi_in_addr,
    input  logic [DATA_W-1:0] msi_in_data,
    input  logic [INTX_N-1:0] intx_level,
    input  logic [ERR_W-1:0]  err_event,
    output logic [MSI_BANKS-1:0] msi_irq,
    output logic [INTX_N-1:0] intx_irq,
    output logic              err_irq
);

    localparam int NVEC  = MSI_BANKS * MSI_BITS;
    localparam int VEC_W = $clog2(NVEC);

    logic msi_hit, eoi_wr;
    logic [MSI_BANKS-1:0][MSI_BITS-1:0] msi_ev, msi_stat, msi_en;
    logic [INTX_N-1:0] int_stat, int_en;
    logic [ERR_W-1:0]  err_stat, err_en;
    bank_ctl_t msi_ctl [MSI_BANKS];
    bank_ctl_t int_ctl [INTX_N];
    bank_ctl_t err_ctl;

    // Inbound message capture: right offset and in-range vector only
    assign msi_hit = msi_in_valid && (msi_in_addr == OFS_MSI_TGT)
                     && (msi_in_data < DATA_W'(NVEC));
    assign eoi_wr  = reg_we && (reg_addr == OFS_EOI);

    pcie_msi_stripe #(.BANKS(MSI_BANKS), .BITS(MSI_BITS)) u_stripe (
        .clk    (clk),
        .rst    (rst),
        .valid  (msi_hit),
        .vector (msi_in_data[VEC_W-1:0]),
        .events (msi_ev)
    );

    generate
        for (genvar b = 0; b < MSI_BANKS; b++) begin : g_msi
            assign msi_ctl[b] = '{
                w1c:    reg_we && (reg_addr == bank_ofs(OFS_MSI_STAT, b)),
                en_set: reg_we && (reg_addr == bank_ofs(OFS_MSI_ENSET, b)),
                en_clr: reg_we && (reg_addr == bank_ofs(OFS_MSI_ENCLR, b)),
                eoi:    eoi_wr && (reg_wdata == DATA_W'(EOI_MSI_BASE + b))
            };
            pcie_irq_bank #(.W(MSI_BITS), .LEVEL(1'b0)) u_bank (
                .clk    (clk),
                .rst    (rst),
                .ctl    (msi_ctl[b]),
                .wbits  (reg_wdata[MSI_BITS-1:0]),
                .src    (msi_ev[b]),
                .status (msi_stat[b]),
                .enable (msi_en[b]),
                .irq    (msi_irq[b])
            );
        end

        for (genvar i = 0; i < INTX_N; i++) begin : g_intx
            assign int_ctl[i] = '{
                w1c:    reg_we && (reg_addr == bank_ofs(OFS_INT_STAT, i)),
                en_set: reg_we && (reg_addr == bank_ofs(OFS_INT_ENSET, i)),
                en_clr: reg_we && (reg_addr == bank_ofs(OFS_INT_ENCLR, i)),
                eoi:    eoi_wr && (reg_wdata == DATA_W'(i))
            };
            pcie_irq_bank #(.W(1), .LEVEL(1'b1)) u_bank (
                .clk    (clk),
                .rst    (rst),
                .ctl    (int_ctl[i]),
                .wbits  (reg_wdata[0]),
                .src    (intx_level[i]),
                .status (int_stat[i]),
                .enable (int_en[i]),
                .irq    (intx_irq[i])
            );
        end
    endgenerate

    assign err_ctl = '{
        w1c:    reg_we && (reg_addr == OFS_ERR_STAT),
        en_set: reg_we && (reg_addr == OFS_ERR_ENSET),
        en_clr: 1'b0,
        eoi:    1'b0
    };

    pcie_irq_bank #(.W(ERR_W), .LEVEL(1'b0)) u_err (
        .clk    (clk),
        .rst    (rst),
        .ctl    (err_ctl),
        .wbits  (reg_wdata[ERR_W-1:0]),
        .src    (err_event),
        .status (err_stat),
        .enable (err_en),
        .irq    (err_irq)
    );

    // Register read decode
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < MSI_BANKS; b++) begin
            if (reg_addr == bank_ofs(OFS_MSI_STAT, b))
                reg_rdata[MSI_BITS-1:0] = msi_stat[b];
            if (reg_addr == bank_ofs(OFS_MSI_ENSET, b) ||
                reg_addr == bank_ofs(OFS_MSI_ENCLR, b))
                reg_rdata[MSI_BITS-1:0] = msi_en[b];
        end
        for (int i = 0; i < INTX_N; i++) begin
            if (reg_addr == bank_ofs(OFS_INT_STAT, i))
                reg_rdata[0] = int_stat[i];
            if (reg_addr == bank_ofs(OFS_INT_ENSET, i) ||
                reg_addr == bank_ofs(OFS_INT_ENCLR, i))
                reg_rdata[0] = int_en[i];
        end
        if (reg_addr == OFS_ERR_STAT)  reg_rdata[ERR_W-1:0] = err_stat;
        if (reg_addr == OFS_ERR_ENSET) reg_rdata[ERR_W-1:0] = err_en;
    end

    // R10
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (msi_irq == '0 && intx_irq == '0 && !err_irq));

    // R1
    bad_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (msi_in_valid && msi_in_addr != OFS_MSI_TGT) |-> (msi_ev == '0));

endmodule

// File: tb/pcie_irq_aggregator_test.sv
module pcie_irq_aggregator_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msi_in_valid = 1'b0;
    logic [11:0] msi_in_addr = '0;
    logic [31:0] msi_in_data = '0;
    logic [3:0]  intx_level = '0;
    logic [5:0]  err_event = '0;
    logic [7:0]  msi_irq;
    logic [3:0]  intx_irq;
    logic        err_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pcie_irq_aggregator uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msi_in_valid(msi_in_valid), .msi_in_addr(msi_in_addr),
        .msi_in_data(msi_in_data), .intx_level(intx_level),
        .err_event(err_event), .msi_irq(msi_irq), .intx_irq(intx_irq),
        .err_irq(err_irq)
    );

    typedef struct packed {
        logic [31:0] vec;
        logic [3:0]  bank;
        logic [3:0]  bpos;
    } vrow_t;

    localparam vrow_t VTAB [6] = '{
        '{32'd0,  4'd0, 4'd0},
        '{32'd7,  4'd7, 4'd0},
        '{32'd8,  4'd0, 4'd1},
        '{32'd13, 4'd5, 4'd1},
        '{32'd26, 4'd2, 4'd3},
        '{32'd31, 4'd7, 4'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic reg_rd(input logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic msi_wr(input logic [11:0] a, input logic [31:0] d);
        msi_in_valid = 1'b1; msi_in_addr = a; msi_in_data = d;
        tick();
        msi_in_valid = 1'b0;
    endtask

    function automatic logic [11:0] ofs(input logic [11:0] base, input int idx);
        return base + 12'(idx * 16);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R10 reset state
        check("R10 msi_irq", 32'(msi_irq), 0);
        check("R10 intx_irq", 32'(intx_irq), 0);
        check("R10 err_irq", 32'(err_irq), 0);
        reg_rd(12'h104, v); check("R10 msi status", v, 0);
        reg_rd(12'h108, v); check("R10 msi enable", v, 0);
        reg_rd(12'h1C8, v); check("R10 err enable", v, 0);

        // R3 enable all message groups
        for (int b = 0; b < 8; b++) reg_wr(ofs(12'h108, b), 32'hF);
        reg_rd(12'h17C, v); check("R3 enable readback", v, 32'hF);

        // R1 R2 R4 striping table
        for (int r = 0; r < 6; r++) begin
            msi_wr(12'h054, VTAB[r].vec);
            reg_rd(ofs(12'h104, int'(VTAB[r].bank)), v);
            check("R1 stripe status", v, 32'(1) << VTAB[r].bpos);
            tick();
            check("R4 line up", 32'(msi_irq), 32'(1) << VTAB[r].bank);
            reg_wr(ofs(12'h104, int'(VTAB[r].bank)), 32'(1) << VTAB[r].bpos);
            reg_rd(ofs(12'h104, int'(VTAB[r].bank)), v);
            check("R2 w1c clears", v, 0);
            tick();
            check("R4 line down", 32'(msi_irq), 0);
        end

        // R3 R4 disabled source stays silent until enabled
        reg_wr(12'h12C, 32'h1);
        reg_rd(12'h128, v); check("R3 enable clear", v, 32'hE);
        msi_wr(12'h054, 32'd2);
        tick();
        check("R4 masked line", 32'(msi_irq), 0);
        reg_rd(12'h124, v); check("R4 masked status kept", v, 32'h1);
        reg_wr(12'h128, 32'h1);
        tick();
        check("R4 line after enable", 32'(msi_irq), 32'h04);
        reg_wr(12'h124, 32'h1);
        tick();

        // R5 end of interrupt gap on message line 3
        msi_wr(12'h054, 32'd3);
        tick();
        check("R5 pre-eoi", 32'(msi_irq[3]), 1);
        reg_wr(12'h050, 32'd7);
        check("R5 gap low", 32'(msi_irq[3]), 0);
        tick();
        check("R5 reassert", 32'(msi_irq[3]), 1);
        reg_wr(12'h134, 32'h1);
        tick();

        // R9 event and clear in the same cycle
        msi_in_valid = 1'b1; msi_in_addr = 12'h054; msi_in_data = 32'd4;
        reg_we = 1'b1; reg_addr = 12'h144; reg_wdata = 32'h1;
        tick();
        msi_in_valid = 1'b0; reg_we = 1'b0;
        reg_rd(12'h144, v); check("R9 msi event wins", v, 32'h1);
        reg_wr(12'h144, 32'h1);
        tick();

        // R1 wrong address and out-of-range vector are ignored
        msi_wr(12'h058, 32'd9);
        reg_rd(12'h114, v); check("R1 wrong address", v, 0);
        msi_wr(12'h054, 32'd40);
        reg_rd(12'h104, v); check("R1 out of range", v, 0);
        tick();
        check("R1 no line", 32'(msi_irq), 0);

        // R6 R7 INTx level tracking
        for (int i = 0; i < 4; i++) reg_wr(ofs(12'h188, i), 32'h1);
        intx_level = 4'b0100;
        tick(); tick();
        check("R7 intx line", 32'(intx_irq), 32'h4);
        reg_rd(12'h1A4, v); check("R6 intx status", v, 1);
        intx_level = 4'b0000;
        tick(); tick();
        check("R7 intx drop", 32'(intx_irq), 0);
        reg_rd(12'h1A4, v); check("R6 intx follows", v, 0);

        // R5 INTx end of interrupt
        intx_level = 4'b0001;
        tick(); tick();
        reg_wr(12'h050, 32'd0);
        check("R5 intx gap", 32'(intx_irq[0]), 0);
        tick();
        check("R5 intx reassert", 32'(intx_irq[0]), 1);
        intx_level = 4'b0000;
        tick();

        // R6 disabled INTx holds
        reg_wr(12'h19C, 32'h1);
        reg_rd(12'h198, v); check("R6 intx enable clear", v, 0);
        intx_level = 4'b0010;
        tick(); tick();
        check("R7 disabled intx", 32'(intx_irq), 0);
        reg_rd(12'h194, v); check("R6 disabled holds", v, 0);
        intx_level = 4'b0000;

        // R8 error status
        reg_wr(12'h1C8, 32'h05);
        err_event = 6'b000010; tick(); err_event = '0;
        reg_rd(12'h1C4, v); check("R8 err latch", v, 32'h02);
        tick();
        check("R8 masked err", 32'(err_irq), 0);
        err_event = 6'b000100; tick(); err_event = '0;
        tick();
        check("R8 err line", 32'(err_irq), 1);
        reg_rd(12'h1C4, v); check("R8 err status", v, 32'h06);
        reg_rd(12'h1C8, v); check("R8 err enable", v, 32'h05);

        // R9 error event beats clear
        err_event = 6'b000100;
        reg_we = 1'b1; reg_addr = 12'h1C4; reg_wdata = 32'h06;
        tick();
        err_event = '0; reg_we = 1'b0;
        reg_rd(12'h1C4, v); check("R9 err event wins", v, 32'h04);
        reg_wr(12'h1C4, 32'h04);
        reg_rd(12'h1C4, v); check("R8 err cleared", v, 0);
        tick();
        check("R8 err line off", 32'(err_irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule